// File: doc/BRIEF.md
# Tiered Reset and Standby Controller

This block takes three asynchronous active-low reset requests (power-on, supply-fail and user) and turns them into the internal reset and standby controls of a small system-on-chip. Every reset output goes low as soon as its request does. It returns high only through a synchronizer on the main clock, so its release is clean.

The resets are tiered. Only power-on reset clears the two timekeeping registers (a count value and a compare value) and sets the cold-start flag. Supply-fail and user reset cause a system reset. That reset puts the block back into Standby and leaves the timekeeping registers and the cold-start flag as they were.

Leaving Standby needs a wake request and then a programmable oscillator settling wait. When the wait ends, the RUN level rises and the peripheral enables turn on. Software reaches the flags and the timekeeping registers through a simple write port. Their values are always visible on output ports.

Top module: `rst_stby_ctrl`

## Requirements
- R1: `sys_rst_n_o` goes low at once when any of `por_n_i`, `pwrfail_n_i` or `ureset_n_i` is low. It returns high on the second rising clock edge at which all three are high.
- R2: `por_rst_n_o` goes low at once with `por_n_i` and returns high on the second rising edge with `por_n_i` high. Whenever `por_rst_n_o` is low, `sys_rst_n_o` is also low.
- R3: While `sys_rst_n_o` is low, the block is held in Standby: `run_o` is low and `osc_en_o` is low.
- R4: `tdata_o` and `tmatch_o` are cleared only while `por_rst_n_o` is low. A write with `wr_sel_i`=1 loads `tdata_o`, and a write with `wr_sel_i`=2 loads `tmatch_o`. Both keep their values through supply-fail and user resets and accept writes during them.
- R5: Status bit 0 (the cold-start flag) is set by power-on reset and is not changed by the other resets. A write with `wr_sel_i`=0 and data bit 0 set clears it.
- R6: Status bit 1 (the woke flag) is cleared by any system reset. It is set on the edge that enters Operating. A write with `wr_sel_i`=0 and data bit 1 set clears it, and the set wins if both happen on the same edge.
- R7: In Standby with `sys_rst_n_o` high, a `wake_i` sampled high at an edge raises `osc_en_o` at that edge and loads N = `wait_cycles_i`. `run_o` then rises N+1 edges later. N=0 gives one edge.
- R8: `wake_i` has no effect outside Standby. Once `run_o` is high, it stays high until a system reset.
- R9: `periph_en_o` bits 1:0 are the serial/infrared ports, bit 2 the timer, bit 3 the codec and bits 5:4 the synchronous serial ports. Bits 7:6 are the display and PWM drives. All eight are 1 in Operating and all eight are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| por_n_i | input | 1 | Power-on reset request, active low, asynchronous |
| pwrfail_n_i | input | 1 | Supply-fail reset request, active low, asynchronous |
| ureset_n_i | input | 1 | User reset request, active low, asynchronous |
| wake_i | input | 1 | Wake request from Standby |
| wait_cycles_i | input | CNT_W | Oscillator settling wait N, in clock cycles |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 time count, 2 time compare, 3 none |
| wr_data_i | input | DW | Write data |
| por_rst_n_o | output | 1 | Power-on reset, active low |
| sys_rst_n_o | output | 1 | System reset, active low |
| run_o | output | 1 | RUN / standby level, high in Operating |
| osc_en_o | output | 1 | Oscillator enable, high while waiting and in Operating |
| periph_en_o | output | 8 | Peripheral enables |
| status_o | output | 2 | {woke flag, cold-start flag} |
| tdata_o | output | DW | Protected time count register |
| tmatch_o | output | DW | Protected time compare register |

## Verification
The bench goes after the points where the reset tiers meet:
- A supply-fail or user reset while the timekeeping registers hold data. A design that wired those registers to the system reset would lose the time.
- A wake pulse that arrives while the system reset synchronizer is still releasing. A design that did not hold the state machine in reset would leave Standby too early.
- Settling waits of five cycles and of zero cycles. An off-by-one counter shows up as `run_o` rising one edge early or late.
- A second wake while already in Operating, and write-one clears of both status flags, including a power-on reset that must set the cold-start flag again after it was cleared.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_STBY = 2'd0,
    ST_OSCW = 2'd1,
    ST_OPER = 2'd2
  } pwr_st_e;

  localparam int unsigned NUM_PERIPH  = 8;
  localparam int unsigned NUM_LVL_EN  = 6;
  localparam int unsigned STAT_W      = 2;
  localparam int unsigned STAT_COLD   = 0;
  localparam int unsigned STAT_WOKE   = 1;

  localparam logic [1:0] SEL_STAT   = 2'd0;
  localparam logic [1:0] SEL_TDATA  = 2'd1;
  localparam logic [1:0] SEL_TMATCH = 2'd2;

endpackage

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_n_i,
  output logic srst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      assign chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign srst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/rsc_pwr_fsm.sv
module rsc_pwr_fsm
  import rsc_pkg::*;
#(
  parameter int unsigned CNT_W  = 22,
  parameter int unsigned NPER   = NUM_PERIPH,
  parameter int unsigned NLVL   = NUM_LVL_EN
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             wake_i,
  input  logic [CNT_W-1:0] wait_cycles_i,
  output logic             run_o,
  output logic             osc_en_o,
  output logic             woke_set_o,
  output logic [NPER-1:0]  periph_en_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  pwr_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_STBY: begin
        if (wake_i) begin
          st_d   = ST_OSCW;
          cnt_d  = wait_cycles_i;
          cnt_en = 1'b1;
        end
      end
      ST_OSCW: begin
        if (cnt_zero) begin
          st_d = ST_OPER;
        end else begin
          cnt_d  = cnt_q - CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      ST_OPER: st_d = ST_OPER;
      default: st_d = ST_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) st_q <= ST_STBY;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_o      = (st_q == ST_OPER);
  assign osc_en_o   = (st_q != ST_STBY);
  assign woke_set_o = (st_q == ST_OSCW) && cnt_zero;

  // Lower group follows the standby level; upper group follows the state.
  generate
    for (genvar g = 0; g < NPER; g++) begin : g_en
      if (g < NLVL) begin : g_lvl
        assign periph_en_o[g] = run_o;
      end else begin : g_state
        assign periph_en_o[g] = (st_q == ST_OPER);
      end
    end
  endgenerate

  // R7: the wait ends in Operating on the following edge
  assert_wait_done_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (st_q == ST_OSCW && cnt_zero) |=> run_o);

  // R7: a wake in Standby loads the wait count and enables the oscillator
  assert_wake_load_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!osc_en_o && wake_i) |=> (osc_en_o && cnt_q == $past(wait_cycles_i)));

  // R8: Operating is left only through reset
  assert_stay_oper_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    run_o |=> run_o);

endmodule

// File: rtl/rsc_aon_regs.sv
module rsc_aon_regs
  import rsc_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk_i,
  input  logic              por_rst_n_i,
  input  logic              sys_rst_n_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              woke_set_i,
  output logic [DW-1:0]     tdata_o,
  output logic [DW-1:0]     tmatch_o,
  output logic [STAT_W-1:0] status_o
);

  logic          wr_stat, wr_td, wr_tm;
  logic          cold_q, cold_d;
  logic          woke_q, woke_d;
  logic [DW-1:0] tdata_q, tmatch_q;

  assign wr_stat = wr_en_i && (wr_sel_i == SEL_STAT);
  assign wr_td   = wr_en_i && (wr_sel_i == SEL_TDATA);
  assign wr_tm   = wr_en_i && (wr_sel_i == SEL_TMATCH);

  always_comb begin
    cold_d = cold_q;
    if (wr_stat && wr_data_i[STAT_COLD]) cold_d = 1'b0;
    woke_d = woke_q;
    if (woke_set_i)                           woke_d = 1'b1;
    else if (wr_stat && wr_data_i[STAT_WOKE]) woke_d = 1'b0;
  end

  // Power-on domain: only the power-on reset touches these.
  always_ff @(posedge clk_i or negedge por_rst_n_i) begin
    if (!por_rst_n_i) cold_q <= 1'b1;
    else              cold_q <= cold_d;
  end

  always_ff @(posedge clk_i or negedge por_rst_n_i) begin
    if (!por_rst_n_i) tdata_q <= '0;
    else if (wr_td)   tdata_q <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge por_rst_n_i) begin
    if (!por_rst_n_i) tmatch_q <= '0;
    else if (wr_tm)   tmatch_q <= wr_data_i;
  end

  // System domain.
  always_ff @(posedge clk_i or negedge sys_rst_n_i) begin
    if (!sys_rst_n_i) woke_q <= 1'b0;
    else              woke_q <= woke_d;
  end

  assign tdata_o              = tdata_q;
  assign tmatch_o             = tmatch_q;
  assign status_o[STAT_COLD]  = cold_q;
  assign status_o[STAT_WOKE]  = woke_q;

  // R4: protected registers change only when written
  assert_tdata_hold_R4: assert property (@(posedge clk_i) disable iff (!por_rst_n_i)
    !wr_td |=> $stable(tdata_o));
  assert_tmatch_hold_R4: assert property (@(posedge clk_i) disable iff (!por_rst_n_i)
    !wr_tm |=> $stable(tmatch_o));

  // R5: cold flag drops only after a write-one
  assert_cold_clear_R5: assert property (@(posedge clk_i) disable iff (!por_rst_n_i)
    $fell(status_o[STAT_COLD]) |-> $past(wr_stat && wr_data_i[STAT_COLD]));

  // R6: entry to Operating sets the woke flag
  assert_woke_set_R6: assert property (@(posedge clk_i) disable iff (!sys_rst_n_i)
    woke_set_i |=> status_o[STAT_WOKE]);

endmodule

// File: rtl/rst_stby_ctrl.sv
module rst_stby_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned CNT_W       = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic             pwrfail_n_i,
  input  logic             ureset_n_i,
  input  logic             wake_i,
  input  logic [CNT_W-1:0] wait_cycles_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             por_rst_n_o,
  output logic             sys_rst_n_o,
  output logic             run_o,
  output logic             osc_en_o,
  output logic [7:0]       periph_en_o,
  output logic [1:0]       status_o,
  output logic [DW-1:0]    tdata_o,
  output logic [DW-1:0]    tmatch_o
);

  logic any_rst_n;
  logic por_rst_n;
  logic sys_rst_n;
  logic woke_set;

  // Power-on reset is part of the combined request, so it forces system reset.
  assign any_rst_n = por_n_i & pwrfail_n_i & ureset_n_i;

  rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk_i    (clk_i),
    .arst_n_i (por_n_i),
    .srst_n_o (por_rst_n)
  );

  rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i    (clk_i),
    .arst_n_i (any_rst_n),
    .srst_n_o (sys_rst_n)
  );

  rsc_pwr_fsm #(.CNT_W(CNT_W), .NPER(NUM_PERIPH), .NLVL(NUM_LVL_EN)) u_fsm (
    .clk_i         (clk_i),
    .rst_n_i       (sys_rst_n),
    .wake_i        (wake_i),
    .wait_cycles_i (wait_cycles_i),
    .run_o         (run_o),
    .osc_en_o      (osc_en_o),
    .woke_set_o    (woke_set),
    .periph_en_o   (periph_en_o)
  );

  rsc_aon_regs #(.DW(DW)) u_regs (
    .clk_i       (clk_i),
    .por_rst_n_i (por_rst_n),
    .sys_rst_n_i (sys_rst_n),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .woke_set_i  (woke_set),
    .tdata_o     (tdata_o),
    .tmatch_o    (tmatch_o),
    .status_o    (status_o)
  );

  assign por_rst_n_o = por_rst_n;
  assign sys_rst_n_o = sys_rst_n;

  // R2: system reset never released while power-on reset is held
  assert_sys_follows_por_R2: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    por_rst_n);

  // R3: system reset holds the block in Standby
  assert_stby_forced_R3: assert property (@(posedge clk_i) disable iff (!por_rst_n)
    !sys_rst_n |-> (!run_o && !osc_en_o));

  // R9: no peripheral enabled without the oscillator running
  assert_en_needs_osc_R9: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (periph_en_o != '0) |-> osc_en_o);

endmodule

// File: tb/test_rst_stby_ctrl.sv
module test_rst_stby_ctrl;

  localparam int DW    = 16;
  localparam int CNT_W = 22;

  logic             clk = 1'b0;
  logic             por_n, pf_n, ur_n, wake;
  logic [CNT_W-1:0] wcyc;
  logic             wr_en;
  logic [1:0]       sel;
  logic [DW-1:0]    wd;
  logic             por_o, sys_o, run, osc;
  logic [7:0]       pen;
  logic [1:0]       stat;
  logic [DW-1:0]    td_o, tm_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rst_stby_ctrl #(.DW(DW), .CNT_W(CNT_W)) i_rst_stby_ctrl (
    .clk_i(clk), .por_n_i(por_n), .pwrfail_n_i(pf_n), .ureset_n_i(ur_n),
    .wake_i(wake), .wait_cycles_i(wcyc), .wr_en_i(wr_en), .wr_sel_i(sel),
    .wr_data_i(wd), .por_rst_n_o(por_o), .sys_rst_n_o(sys_o), .run_o(run),
    .osc_en_o(osc), .periph_en_o(pen), .status_o(stat), .tdata_o(td_o),
    .tmatch_o(tm_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit mp1, mp2, ms1, ms2;
  int st;          // 0 standby, 1 settling, 2 operating
  int cnt;
  bit cold, woke, setw;
  int td, tm;

  always @(posedge clk) begin
    if (!por_n) begin mp1 = 0; mp2 = 0; end
    if (!(por_n && pf_n && ur_n)) begin ms1 = 0; ms2 = 0; end
    if (!mp2) begin
      cold = 1; td = 0; tm = 0;
    end else if (wr_en) begin
      if (sel == 0 && wd[0]) cold = 0;
      if (sel == 1) td = wd;
      if (sel == 2) tm = wd;
    end
    if (!ms2) begin
      st = 0; cnt = 0; woke = 0;
    end else begin
      setw = (st == 1 && cnt == 0);
      if (st == 0) begin
        if (wake) begin st = 1; cnt = int'(wcyc); end
      end else if (st == 1) begin
        if (cnt == 0) st = 2; else cnt = cnt - 1;
      end
      if (setw) woke = 1;
      else if (wr_en && sel == 0 && wd[1]) woke = 0;
    end
    if (por_n) begin mp2 = mp1; mp1 = 1; end
    if (por_n && pf_n && ur_n) begin ms2 = ms1; ms1 = 1; end
    #1;
    chk("R1 sys_rst_n", 32'(sys_o), 32'(ms2));
    chk("R2 por_rst_n", 32'(por_o), 32'(mp2));
    chk("R3 R7 R8 run", 32'(run), 32'(st == 2));
    chk("R3 R7 osc_en", 32'(osc), 32'(st != 0));
    chk("R9 periph_en", 32'(pen), (st == 2) ? 32'hFF : 32'h0);
    chk("R5 cold flag", 32'(stat[0]), 32'(cold));
    chk("R6 woke flag", 32'(stat[1]), 32'(woke));
    chk("R4 tdata", 32'(td_o), 32'(td));
    chk("R4 tmatch", 32'(tm_o), 32'(tm));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] s, logic [DW-1:0] d);
    wr_en = 1'b1; sel = s; wd = d;
    tick(1);
    wr_en = 1'b0; sel = 2'd3; wd = '0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(1); wake = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    por_n = 0; pf_n = 1; ur_n = 1; wake = 0; wcyc = 22'd5;
    wr_en = 0; sel = 2'd3; wd = '0;
    tick(4);
    por_n = 1; tick(4);                       // R2 release timing
    wr(2'd1, 16'h1234); wr(2'd2, 16'hBEEF);   // R4 load protected regs
    pulse_wake(); tick(8);                    // R7 wait of five
    pulse_wake(); tick(2);                    // R8 wake in Operating
    wr(2'd0, 16'h0002); tick(2);              // R6 clear woke
    pf_n = 0; tick(2); pf_n = 1;              // R1 supply-fail reset
    tick(1); pulse_wake(); tick(3);           // R3 wake during release
    wcyc = '0; pulse_wake(); tick(3);         // R7 zero wait
    wr(2'd0, 16'h0001); tick(2);              // R5 clear cold
    ur_n = 0; tick(1); wr(2'd1, 16'h5A5A);    // R4 write under user reset
    tick(1); ur_n = 1; tick(4);
    wcyc = 22'd2; pulse_wake(); tick(5);
    por_n = 0; pf_n = 0; tick(2); pf_n = 1;   // R2 R5 power-on again
    tick(1); por_n = 1; tick(5);
    pulse_wake(); tick(6);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule